// File: doc/BRIEF.md
# Prefixed Instruction Boundary Predecoder

This block sits in the fetch path of a core whose instructions are normally one 32-bit word but may also be a 64-bit pair: a prefix word followed at once by a suffix word. It accepts one fetched word per cycle over a valid/ready handshake. Each word comes with its byte address and a flag saying whether control flow arrived at it as a branch target. For every accepted word it produces one registered tag: plain word, prefix, or suffix.

For pairs, the tag carries the two-bit prefix format type. It also reports whether the suffix lives in an alternate opcode space or is an ordinary word instruction that the prefix modifies. Four fault flags cover the malformed cases: a suffix that carries the prefix opcode, control entering a suffix slot, a pending prefix abandoned by such an entry, and a prefix placed so that its suffix would fall into the next 64-byte line. A flush input discards any pending pairing and any held result. Operand decode and execution are handled downstream.

Top module: `prefix_predecoder`

## Requirements
- R1: After reset `outValid` is 0, `inReady` is 1, and the first accepted word is classified as a first word, not a suffix.
- R2: A first-position word is a prefix when its six most significant bits (`inWord[31:26]`) equal 6'b000001. It is tagged 2'b01 with `outPrefixType = inWord[25:24]`. Any other first-position word is tagged 2'b00 with type 0 and both space flags 0.
- R3: The word accepted right after a prefix (without a fault that drops the pairing) is tagged 2'b10 and carries the type of its prefix. The word after that is classified as a first word again.
- R4: For prefix and suffix rows, the high type bit selects the space. When it is 0, `outAltSpace` is 1 and `outModifiesWord` is 0. When it is 1, the two flags are the other way round.
- R5: A suffix-position word whose top six bits are 6'b000001 is tagged 2'b10 with `faultIllegal` set. It does not open a new pair, so the next word is a first word.
- R6: A branch-target word that arrives in the suffix slot sets both `faultBadTarget` and `faultIncomplete`. It drops the pending prefix and is itself classified as a first word, and may open a new pair. A branch target in first position raises no fault.
- R7: A prefix whose address has bits 5:2 all ones is tagged 2'b01 with `faultAlign` set. It does not open a pair. A prefix at any other word offset raises no alignment fault.
- R8: While `flush` is high, `inReady` is 0. After a flush cycle, `outValid` is 0 and any pending pairing is dropped.
- R9: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and all outputs and the pairing state hold.
- R10: With `outReady` high, one word is accepted per cycle. Its result appears one clock after acceptance, and `outValid` falls after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Fetched word is present |
| inReady | output | 1 | Block can take a word this cycle |
| inWord | input | 32 | Fetched instruction word |
| inAddr | input | 32 | Byte address of the word |
| inBranchTarget | input | 1 | Word was reached by a control transfer |
| flush | input | 1 | Drop pending pairing and held result |
| outValid | output | 1 | Result row is valid |
| outReady | input | 1 | Consumer takes the result row |
| outTag | output | 2 | 00 word, 01 prefix, 10 suffix |
| outPrefixType | output | 2 | Prefix format type of the pair |
| outAltSpace | output | 1 | Suffix is in the alternate opcode space |
| outModifiesWord | output | 1 | Suffix is a defined word the prefix modifies |
| faultIllegal | output | 1 | Suffix carried the prefix opcode |
| faultBadTarget | output | 1 | Control entered a suffix slot |
| faultIncomplete | output | 1 | Pending prefix dropped before its suffix |
| faultAlign | output | 1 | Prefix suffix would cross a 64-byte line |

## Verification
The stream is driven with runs of plain words, well-formed pairs of all four types, a prefix opcode repeated in the suffix slot, and branch targets placed in both first and suffix position. Comparing these shows whether the pairing state advances, closes and reopens at the right words, and whether type and space flags follow the prefix. Prefixes at the last and second-to-last word of a line tell the alignment rule apart from an off-by-one. Flush and a stalled consumer are mixed into a pair to show that pairing state is dropped or held as required.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  typedef enum logic [1:0] {
    TAG_WORD   = 2'b00,
    TAG_PREFIX = 2'b01,
    TAG_SUFFIX = 2'b10
  } tag_e;

  typedef enum logic {
    ST_FIRST  = 1'b0,
    ST_SUFFIX = 1'b1
  } pair_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;      // word taken this cycle
    logic asSuffix;    // accepted word sits in the suffix slot
    logic openPair;    // accepted word opens a pair
    logic dropPending; // branch target broke a pending pair
    logic flushOut;    // clear the result row
  } ctrl_s;

endpackage

// File: rtl/ppd_control.sv
module ppd_control
  import ppd_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inBranchTarget,
  input  logic  flush,
  input  logic  outValid,
  input  logic  outReady,
  input  logic  isPrefixOp,
  input  logic  crossLine,
  output logic  inReady,
  output ctrl_s ctrl
);

  pair_state_e state, stateNext;
  logic acceptNow, suffixSlot;

  assign inReady    = (!outValid || outReady) && !flush;
  assign acceptNow  = inValid && inReady;
  assign suffixSlot = (state == ST_SUFFIX);

  always_comb begin
    ctrl.accept      = acceptNow;
    ctrl.asSuffix    = acceptNow && suffixSlot && !inBranchTarget;
    ctrl.dropPending = acceptNow && suffixSlot && inBranchTarget;
    ctrl.openPair    = acceptNow && !ctrl.asSuffix && isPrefixOp && !crossLine;
    ctrl.flushOut    = flush;
  end

  always_comb begin
    stateNext = state;
    if (flush)          stateNext = ST_FIRST;
    else if (acceptNow) stateNext = ctrl.openPair ? ST_SUFFIX : ST_FIRST;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FIRST;
    else       state <= stateNext;
  end

  AST_PAIR_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.asSuffix |=> state == ST_FIRST); // R3
  AST_ILLEGAL_NO_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.asSuffix && isPrefixOp) |=> state == ST_FIRST); // R5
  AST_ALIGN_NO_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (acceptNow && !suffixSlot && isPrefixOp && crossLine) |=> state == ST_FIRST); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> state == ST_FIRST); // R8
  AST_STALL_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!acceptNow && !flush) |=> $stable(state)); // R9

endmodule

// File: rtl/ppd_datapath.sv
module ppd_datapath
  import ppd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int OPC_W      = 6,
  parameter int PREFIX_OPC = 1,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic [WORD_W-1:0] inWord,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              outReady,
  output logic              isPrefixOp,
  output logic              crossLine,
  output logic              outValid,
  output logic [1:0]        outTag,
  output logic [1:0]        outPrefixType,
  output logic              outAltSpace,
  output logic              outModifiesWord,
  output logic              faultIllegal,
  output logic              faultBadTarget,
  output logic              faultIncomplete,
  output logic              faultAlign
);

  localparam int OPC_LSB  = WORD_W - OPC_W;
  localparam int TYPE_MSB = OPC_LSB - 1;
  localparam int TYPE_LSB = OPC_LSB - 2;
  localparam int LINE_LSB = $clog2(WORD_W / 8);
  localparam int LINE_MSB = $clog2(LINE_BYTES) - 1;
  localparam logic [OPC_W-1:0] PREFIX_CODE = OPC_W'(PREFIX_OPC);

  logic [1:0] heldType, wordType;
  tag_e       nextTag;
  logic [1:0] nextType;
  logic       nextAlt, nextMod, nextIllegal, nextAlign;

  assign isPrefixOp = (inWord[WORD_W-1:OPC_LSB] == PREFIX_CODE);
  assign crossLine  = &inAddr[LINE_MSB:LINE_LSB];
  assign wordType   = inWord[TYPE_MSB:TYPE_LSB];

  always_comb begin
    nextTag     = TAG_WORD;
    nextType    = 2'b00;
    nextAlt     = 1'b0;
    nextMod     = 1'b0;
    nextIllegal = 1'b0;
    nextAlign   = 1'b0;
    if (ctrl.asSuffix) begin
      nextTag     = TAG_SUFFIX;
      nextType    = heldType;
      nextAlt     = !heldType[1];
      nextMod     = heldType[1];
      nextIllegal = isPrefixOp;
    end else if (isPrefixOp) begin
      nextTag   = TAG_PREFIX;
      nextType  = wordType;
      nextAlt   = !wordType[1];
      nextMod   = wordType[1];
      nextAlign = crossLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid        <= 1'b0;
      outTag          <= TAG_WORD;
      outPrefixType   <= 2'b00;
      outAltSpace     <= 1'b0;
      outModifiesWord <= 1'b0;
      faultIllegal    <= 1'b0;
      faultBadTarget  <= 1'b0;
      faultIncomplete <= 1'b0;
      faultAlign      <= 1'b0;
      heldType        <= 2'b00;
    end else begin
      if (ctrl.flushOut) begin
        outValid <= 1'b0;
      end else if (ctrl.accept) begin
        outValid        <= 1'b1;
        outTag          <= nextTag;
        outPrefixType   <= nextType;
        outAltSpace     <= nextAlt;
        outModifiesWord <= nextMod;
        faultIllegal    <= nextIllegal;
        faultBadTarget  <= ctrl.dropPending;
        faultIncomplete <= ctrl.dropPending;
        faultAlign      <= nextAlign;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (ctrl.openPair) heldType <= wordType;
    end
  end

  AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outTag != 2'b11); // R2
  AST_SPACE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag != TAG_WORD) |-> outAltSpace != outModifiesWord); // R4
  AST_ILLEGAL_ON_SUFFIX: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultIllegal) |-> outTag == TAG_SUFFIX); // R5
  AST_ALIGN_ON_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultAlign) |-> outTag == TAG_PREFIX); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !ctrl.flushOut) |=>
      (outValid && $stable(outTag) && $stable(outPrefixType))); // R9

endmodule

// File: rtl/prefix_predecoder.sv
module prefix_predecoder
  import ppd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int OPC_W      = 6,
  parameter int PREFIX_OPC = 1,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inBranchTarget,
  input  logic              flush,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outTag,
  output logic [1:0]        outPrefixType,
  output logic              outAltSpace,
  output logic              outModifiesWord,
  output logic              faultIllegal,
  output logic              faultBadTarget,
  output logic              faultIncomplete,
  output logic              faultAlign
);

  ctrl_s ctrl;
  logic  isPrefixOp, crossLine;

  ppd_control u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBranchTarget(inBranchTarget),
    .flush(flush), .outValid(outValid), .outReady(outReady),
    .isPrefixOp(isPrefixOp), .crossLine(crossLine),
    .inReady(inReady), .ctrl(ctrl)
  );

  ppd_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W),
    .PREFIX_OPC(PREFIX_OPC), .LINE_BYTES(LINE_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inWord(inWord), .inAddr(inAddr),
    .outReady(outReady), .isPrefixOp(isPrefixOp), .crossLine(crossLine),
    .outValid(outValid), .outTag(outTag), .outPrefixType(outPrefixType),
    .outAltSpace(outAltSpace), .outModifiesWord(outModifiesWord),
    .faultIllegal(faultIllegal), .faultBadTarget(faultBadTarget),
    .faultIncomplete(faultIncomplete), .faultAlign(faultAlign)
  );

endmodule

// File: tb/tb_prefix_predecoder.sv
`timescale 1ns/1ps
module tb_prefix_predecoder;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inBranchTarget = 1'b0, flush = 1'b0, outReady = 1'b1;
  logic [31:0] inWord = '0, inAddr = '0;
  logic inReady, outValid, outAltSpace, outModifiesWord;
  logic faultIllegal, faultBadTarget, faultIncomplete, faultAlign;
  logic [1:0] outTag, outPrefixType;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prefix_predecoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .inAddr(inAddr), .inBranchTarget(inBranchTarget),
    .flush(flush), .outValid(outValid), .outReady(outReady),
    .outTag(outTag), .outPrefixType(outPrefixType), .outAltSpace(outAltSpace),
    .outModifiesWord(outModifiesWord), .faultIllegal(faultIllegal),
    .faultBadTarget(faultBadTarget), .faultIncomplete(faultIncomplete),
    .faultAlign(faultAlign)
  );

  localparam logic [31:0] PLAIN = 32'h7C00_1234;
  localparam logic [1:0] W = 2'b00, P = 2'b01, S = 2'b10;

  function automatic logic [31:0] mkPrefix(input logic [1:0] t);
    return {6'b000001, t, 24'h00_ABCD};
  endfunction

  // {valid, tag, type, alt, mod, illegal, badTarget, incomplete, align}
  task automatic expectRow(input string req, input logic [1:0] tag, input logic [1:0] typ,
                           input logic alt, input logic md, input logic [3:0] flt);
    logic [10:0] got, exp;
    got = {outValid, outTag, outPrefixType, outAltSpace, outModifiesWord,
           faultIllegal, faultBadTarget, faultIncomplete, faultAlign};
    exp = {1'b1, tag, typ, alt, md, flt};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s row actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic expectBit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  // drive at negedge, result sampled at next negedge
  task automatic push(input logic [31:0] w, input logic [31:0] a, input logic bt);
    inWord = w; inAddr = a; inBranchTarget = bt; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; inBranchTarget = 1'b0;
  endtask

  task automatic idle();
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic testReset();
    expectBit("R1 outValid", outValid, 1'b0);
    expectBit("R1 inReady", inReady, 1'b1);
    push(PLAIN, 32'h1000, 1'b0);
    expectRow("R1 first word", W, 2'b00, 0, 0, 4'b0000);
  endtask

  task automatic testPlain();
    push(32'h3800_0001, 32'h1004, 1'b0);
    expectRow("R2 plain", W, 2'b00, 0, 0, 4'b0000);
    push(32'h0800_0000, 32'h1008, 1'b0); // opcode 000010, not a prefix
    expectRow("R2 near opcode", W, 2'b00, 0, 0, 4'b0000);
    idle();
    expectBit("R10 drains", outValid, 1'b0);
  endtask

  task automatic testPairs();
    for (int t = 0; t < 4; t++) begin
      logic [1:0] ty;
      ty = 2'(t);
      push(mkPrefix(ty), 32'h2000 + 8 * t, 1'b0);
      expectRow("R2 R4 prefix", P, ty, !ty[1], ty[1], 4'b0000);
      push(PLAIN, 32'h2004 + 8 * t, 1'b0);
      expectRow("R3 R4 suffix", S, ty, !ty[1], ty[1], 4'b0000);
    end
    push(PLAIN, 32'h2020, 1'b0);
    expectRow("R3 after pair", W, 2'b00, 0, 0, 4'b0000);
  endtask

  task automatic testIllegal();
    push(mkPrefix(2'b10), 32'h3000, 1'b0);
    expectRow("R5 prefix", P, 2'b10, 0, 1, 4'b0000);
    push(mkPrefix(2'b01), 32'h3004, 1'b0);
    expectRow("R5 illegal suffix", S, 2'b10, 0, 1, 4'b1000);
    push(PLAIN, 32'h3008, 1'b0);
    expectRow("R5 no new pair", W, 2'b00, 0, 0, 4'b0000);
  endtask

  task automatic testBranchTarget();
    push(PLAIN, 32'h4000, 1'b1);
    expectRow("R6 target first", W, 2'b00, 0, 0, 4'b0000);
    push(mkPrefix(2'b00), 32'h4004, 1'b0);
    expectRow("R6 prefix", P, 2'b00, 1, 0, 4'b0000);
    push(PLAIN, 32'h4008, 1'b1);
    expectRow("R6 target in suffix", W, 2'b00, 0, 0, 4'b0110);
    push(mkPrefix(2'b11), 32'h4010, 1'b0);
    expectRow("R6 prefix again", P, 2'b11, 0, 1, 4'b0000);
    push(mkPrefix(2'b01), 32'h4020, 1'b1);
    expectRow("R6 target prefix", P, 2'b01, 1, 0, 4'b0110);
    push(PLAIN, 32'h4024, 1'b0);
    expectRow("R6 reopened pair", S, 2'b01, 1, 0, 4'b0000);
  endtask

  task automatic testAlign();
    push(mkPrefix(2'b11), 32'h5038, 1'b0);
    expectRow("R7 in line", P, 2'b11, 0, 1, 4'b0000);
    push(PLAIN, 32'h503C, 1'b0);
    expectRow("R7 suffix", S, 2'b11, 0, 1, 4'b0000);
    push(mkPrefix(2'b01), 32'h507C, 1'b0);
    expectRow("R7 crossing", P, 2'b01, 1, 0, 4'b0001);
    push(PLAIN, 32'h5080, 1'b0);
    expectRow("R7 no pair", W, 2'b00, 0, 0, 4'b0000);
  endtask

  task automatic testFlush();
    push(mkPrefix(2'b10), 32'h6000, 1'b0);
    inWord = PLAIN; inValid = 1'b1; flush = 1'b1;
    #1 expectBit("R8 inReady low", inReady, 1'b0);
    @(posedge clk); @(negedge clk);
    flush = 1'b0; inValid = 1'b0;
    expectBit("R8 outValid cleared", outValid, 1'b0);
    push(PLAIN, 32'h6004, 1'b0);
    expectRow("R8 pairing dropped", W, 2'b00, 0, 0, 4'b0000);
  endtask

  task automatic testStall();
    idle();
    outReady = 1'b0;
    push(mkPrefix(2'b01), 32'h7000, 1'b0);
    expectRow("R9 taken", P, 2'b01, 1, 0, 4'b0000);
    inWord = PLAIN; inAddr = 32'h7004; inValid = 1'b1;
    #1 expectBit("R9 inReady low", inReady, 1'b0);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    expectRow("R9 held", P, 2'b01, 1, 0, 4'b0000);
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    expectRow("R9 R10 state held", S, 2'b01, 1, 0, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testPairs();
    testIllegal();
    testBranchTarget();
    testAlign();
    testFlush();
    testStall();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule